// File: doc/BRIEF.md
# Program-Flow Trace Recorder

This block captures every change of program flow reported by a processor core and stores it, as an eight-byte record, in a small SRAM. Each record has two 32-bit words. The first word holds where the flow left and a flag that marks exceptions or debug-state jumps. The second word holds where the flow went and a flag that marks the first record of a new capture run. The block keeps a write pointer, counted in records, that wraps inside a power-of-two window. A 5-bit size code selects the window, and the pointer bits above the window never change. A sticky flag records each wrap.

Software programs four 32-bit registers through a simple register port: position, control, flow and base. The byte offsets 0x0, 0x4, 0x8 and 0xC are selected by `reg_sel` values 0 to 3. A watermark pointer in the flow register can end the capture, or can raise a halt request towards the core, when the write pointer reaches it. Two external signals can start and stop the capture, each only when its own control bit allows it.

Top module: `trace_buffer`

## Requirements
- R1: After reset the control register reads 0x0000_0080 and the position, flow and base registers read 0. `sram_we` and `dbg_req` are low. Register reads are combinational on `reg_sel`, and unimplemented bits read 0.
- R2: Control register layout: bit 31 capture enable, bit 9 halt request, bit 8 and bit 7 plain storage bits, bit 6 external-stop permit, bit 5 external-start permit, bits 4:0 window size code. Each of these reads back what was written.
- R3: The position register holds the record pointer in bits PTR_MSB:3 and the wrap flag in bit 2. The pointer advances by one record (8 bytes) only after both words of a record are written.
- R4: With size code k the window is 16<<k bytes, so only the lowest k+1 pointer bits count and the bits above hold. When the counting bits roll over to zero, bit 2 is set, and it stays set until software writes position.
- R5: A branch accepted at a clock edge produces writes in the next two cycles. The first goes to base + pointer*8 and the second to that address + 4.
- R6: Word 0 is the source address (bits 31:1) with bit 0 = the atomic flag. The atomic flag is 1 for exception entry or a debug-state jump and 0 for a normal branch.
- R7: Word 1 is the destination address (bits 31:1) with bit 0 = the start flag. The start flag is 1 for the first record after the capture was disabled and enabled again, including the first record after reset, and 0 otherwise.
- R8: A branch is ignored while capture is disabled, and also in the cycle in which the first word of a record is being written. An ignored branch causes no SRAM write and no pointer change.
- R9: `ext_start` sets the enable only when control bit 5 is 1. `ext_stop` clears it only when control bit 6 is 1. If both are active in the same cycle, the stop wins.
- R10: Flow register bits PTR_MSB:3 hold the watermark pointer, and flow bit 0 is auto-stop. When the pointer advances to the watermark with auto-stop set, the capture enable clears.
- R11: Flow bit 1 is auto-halt. When the pointer advances to the watermark with auto-halt set, control bit 9 is set. `dbg_req` follows bit 9, and bit 9 stays set until software writes it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 position, 1 control, 2 flow, 3 base |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| br_valid | input | 1 | Program-flow change reported this cycle |
| br_src | input | 31 | Source address bits 31:1 |
| br_dst | input | 31 | Destination address bits 31:1 |
| br_atomic | input | 1 | 1 = exception entry or debug-state jump |
| ext_start | input | 1 | External capture start |
| ext_stop | input | 1 | External capture stop |
| sram_we | output | 1 | SRAM word write strobe |
| sram_addr | output | 32 | SRAM byte address |
| sram_wdata | output | 32 | SRAM write word |
| dbg_req | output | 1 | Halt request to the core |

## Verification
The bench builds the block with PTR_MSB = 9, which gives a seven-bit record pointer. With this setting a size code of 7 already covers every pointer bit, while codes 0 and 1 give two-record and four-record windows. Those small windows make wrap, the upper-bit hold and the sticky wrap flag reachable in a few records. The short pointer also lets the watermark be hit after one or two records, so auto-stop, auto-halt, restart start flags and the external start and stop priority all fit in short directed runs.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int unsigned SIZE_W = 5;

  typedef enum logic [1:0] {
    REG_POS  = 2'd0,
    REG_CTRL = 2'd1,
    REG_FLOW = 2'd2,
    REG_BASE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    PK_IDLE = 2'd0,
    PK_SRC  = 2'd1,
    PK_DST  = 2'd2
  } pk_state_e;

  localparam int unsigned CTL_EN     = 31;
  localparam int unsigned CTL_HALT   = 9;
  localparam int unsigned CTL_STORE1 = 8;
  localparam int unsigned CTL_STORE0 = 7;
  localparam int unsigned CTL_STOPOK = 6;
  localparam int unsigned CTL_STRTOK = 5;
endpackage

// File: rtl/trc_step.sv
// Record pointer advance inside a power-of-two window.
module trc_step #(
  parameter int unsigned PW = 10,
  parameter int unsigned SW = 5
) (
  input  logic [PW-1:0] cur,
  input  logic [SW-1:0] size_code,
  output logic [PW-1:0] nxt,
  output logic          wrapped
);
  logic [PW-1:0] low_m;
  logic [PW-1:0] inc;

  // bit i counts when i <= size_code (window holds 2^(size_code+1) records)
  for (genvar i = 0; i < PW; i++) begin : g_low
    assign low_m[i] = (32'(i) <= 32'(size_code));
  end

  assign inc     = cur + PW'(1);
  assign nxt     = (cur & ~low_m) | (inc & low_m);
  assign wrapped = ((cur & low_m) == low_m);
endmodule

// File: rtl/trc_regs.sv
// Position, control, flow and base registers with watermark handling.
module trc_regs
  import trc_pkg::*;
#(
  parameter int unsigned PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          ext_start,
  input  logic          ext_stop,
  input  logic          pkt_done,
  output logic          trace_en,
  output logic          halt_req,
  output logic [PW-1:0] ptr,
  output logic [31:0]   base
);
  localparam int unsigned PTOP = PW + 2;

  logic              en_q, en_d;
  logic              halt_q, halt_d;
  logic              st1_q, st1_d;
  logic              st0_q, st0_d;
  logic              stopok_q, stopok_d;
  logic              strtok_q, strtok_d;
  logic [SIZE_W-1:0] size_q, size_d;
  logic [PW-1:0]     ptr_q, ptr_d;
  logic              wrap_q, wrap_d;
  logic [PW-1:0]     wm_q, wm_d;
  logic              ahalt_q, ahalt_d;
  logic              astop_q, astop_d;
  logic [31:0]       base_q, base_d;

  logic [PW-1:0]     step_nxt;
  logic              step_wrap;
  logic              wm_hit;

  trc_step #(.PW(PW), .SW(SIZE_W)) u_step (
    .cur       (ptr_q),
    .size_code (size_q),
    .nxt       (step_nxt),
    .wrapped   (step_wrap)
  );

  assign wm_hit = pkt_done && (step_nxt == wm_q);

  always_comb begin
    en_d     = en_q;
    halt_d   = halt_q;
    st1_d    = st1_q;
    st0_d    = st0_q;
    stopok_d = stopok_q;
    strtok_d = strtok_q;
    size_d   = size_q;
    ptr_d    = ptr_q;
    wrap_d   = wrap_q;
    wm_d     = wm_q;
    ahalt_d  = ahalt_q;
    astop_d  = astop_q;
    base_d   = base_q;
    if (reg_we) begin
      case (reg_sel_e'(reg_sel))
        REG_POS: begin
          ptr_d  = reg_wdata[PTOP:3];
          wrap_d = reg_wdata[2];
        end
        REG_CTRL: begin
          en_d     = reg_wdata[CTL_EN];
          halt_d   = reg_wdata[CTL_HALT];
          st1_d    = reg_wdata[CTL_STORE1];
          st0_d    = reg_wdata[CTL_STORE0];
          stopok_d = reg_wdata[CTL_STOPOK];
          strtok_d = reg_wdata[CTL_STRTOK];
          size_d   = reg_wdata[SIZE_W-1:0];
        end
        REG_FLOW: begin
          wm_d    = reg_wdata[PTOP:3];
          ahalt_d = reg_wdata[1];
          astop_d = reg_wdata[0];
        end
        default: base_d = reg_wdata;
      endcase
    end
    if (ext_start && strtok_q) en_d = 1'b1;
    if (ext_stop && stopok_q)  en_d = 1'b0;
    if (pkt_done) begin
      ptr_d = step_nxt;
      if (step_wrap) wrap_d = 1'b1;
    end
    if (wm_hit && astop_q) en_d   = 1'b0;
    if (wm_hit && ahalt_q) halt_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      halt_q   <= 1'b0;
      st1_q    <= 1'b0;
      st0_q    <= 1'b1;
      stopok_q <= 1'b0;
      strtok_q <= 1'b0;
      size_q   <= '0;
      ptr_q    <= '0;
      wrap_q   <= 1'b0;
      wm_q     <= '0;
      ahalt_q  <= 1'b0;
      astop_q  <= 1'b0;
      base_q   <= '0;
    end else begin
      en_q     <= en_d;
      halt_q   <= halt_d;
      st1_q    <= st1_d;
      st0_q    <= st0_d;
      stopok_q <= stopok_d;
      strtok_q <= strtok_d;
      size_q   <= size_d;
      ptr_q    <= ptr_d;
      wrap_q   <= wrap_d;
      wm_q     <= wm_d;
      ahalt_q  <= ahalt_d;
      astop_q  <= astop_d;
      base_q   <= base_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel_e'(reg_sel))
      REG_POS: begin
        reg_rdata[PTOP:3] = ptr_q;
        reg_rdata[2]      = wrap_q;
      end
      REG_CTRL: begin
        reg_rdata[CTL_EN]       = en_q;
        reg_rdata[CTL_HALT]     = halt_q;
        reg_rdata[CTL_STORE1]   = st1_q;
        reg_rdata[CTL_STORE0]   = st0_q;
        reg_rdata[CTL_STOPOK]   = stopok_q;
        reg_rdata[CTL_STRTOK]   = strtok_q;
        reg_rdata[SIZE_W-1:0]   = size_q;
      end
      REG_FLOW: begin
        reg_rdata[PTOP:3] = wm_q;
        reg_rdata[1]      = ahalt_q;
        reg_rdata[0]      = astop_q;
      end
      default: reg_rdata = base_q;
    endcase
  end

  assign trace_en = en_q;
  assign halt_req = halt_q;
  assign ptr      = ptr_q;
  assign base     = base_q;
endmodule

// File: rtl/trc_pack.sv
// Record capture and two-cycle SRAM write sequencing.
module trc_pack
  import trc_pkg::*;
#(
  parameter int unsigned PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          br_valid,
  input  logic [31:1]   br_src,
  input  logic [31:1]   br_dst,
  input  logic          br_atomic,
  input  logic          trace_en,
  input  logic [PW-1:0] ptr,
  input  logic [31:0]   base,
  output logic          sram_we,
  output logic [31:0]   sram_addr,
  output logic [31:0]   sram_wdata,
  output logic          pkt_done
);
  pk_state_e   st_q, st_d;
  logic [31:1] src_q, src_d;
  logic [31:1] dst_q, dst_d;
  logic        atom_q, atom_d;
  logic        sflag_q, sflag_d;
  logic        pend_q, pend_d;
  logic        take;
  logic [31:0] rec_off;

  assign take = br_valid && trace_en && (st_q != PK_SRC);

  always_comb begin
    st_d    = st_q;
    src_d   = src_q;
    dst_d   = dst_q;
    atom_d  = atom_q;
    sflag_d = sflag_q;
    pend_d  = pend_q;
    case (st_q)
      PK_SRC:  st_d = PK_DST;
      default: st_d = PK_IDLE;
    endcase
    if (!trace_en) pend_d = 1'b1;
    if (take) begin
      st_d    = PK_SRC;
      src_d   = br_src;
      dst_d   = br_dst;
      atom_d  = br_atomic;
      sflag_d = pend_q;
      pend_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PK_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      atom_q  <= 1'b0;
      sflag_q <= 1'b0;
      pend_q  <= 1'b1;
    end else begin
      st_q    <= st_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      atom_q  <= atom_d;
      sflag_q <= sflag_d;
      pend_q  <= pend_d;
    end
  end

  assign rec_off    = 32'({ptr, 3'b000});
  assign sram_we    = (st_q == PK_SRC) || (st_q == PK_DST);
  assign sram_addr  = base + rec_off + ((st_q == PK_DST) ? 32'd4 : 32'd0);
  assign sram_wdata = (st_q == PK_DST) ? {dst_q, sflag_q} : {src_q, atom_q};
  assign pkt_done   = (st_q == PK_DST);
endmodule

// File: rtl/trace_buffer.sv
module trace_buffer
  import trc_pkg::*;
#(
  parameter int unsigned PTR_MSB = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        br_valid,
  input  logic [31:1] br_src,
  input  logic [31:1] br_dst,
  input  logic        br_atomic,
  input  logic        ext_start,
  input  logic        ext_stop,
  output logic        sram_we,
  output logic [31:0] sram_addr,
  output logic [31:0] sram_wdata,
  output logic        dbg_req
);
  localparam int unsigned PW = PTR_MSB - 2;

  logic [1:0]    rs_q;
  logic          rst_sync_n;
  logic          trace_en;
  logic          pkt_done;
  logic [PW-1:0] ptr;
  logic [31:0]   base;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  trc_regs #(.PW(PW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ext_start (ext_start),
    .ext_stop  (ext_stop),
    .pkt_done  (pkt_done),
    .trace_en  (trace_en),
    .halt_req  (dbg_req),
    .ptr       (ptr),
    .base      (base)
  );

  trc_pack #(.PW(PW)) u_pack (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .br_valid   (br_valid),
    .br_src     (br_src),
    .br_dst     (br_dst),
    .br_atomic  (br_atomic),
    .trace_en   (trace_en),
    .ptr        (ptr),
    .base       (base),
    .sram_we    (sram_we),
    .sram_addr  (sram_addr),
    .sram_wdata (sram_wdata),
    .pkt_done   (pkt_done)
  );
endmodule

// File: rtl/trc_chk.sv
module trc_chk #(
  parameter int unsigned PW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trace_en,
  input logic          pkt_done,
  input logic [PW-1:0] ptr,
  input logic          reg_we,
  input logic [1:0]    reg_sel,
  input logic          br_atomic,
  input logic          sram_we,
  input logic [31:0]   sram_addr,
  input logic [31:0]   sram_wdata,
  input logic          dbg_req
);
  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= 2'd0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  AST_PAIR_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) && $rose(sram_we) |=> sram_we && (sram_addr == $past(sram_addr) + 32'd4)); // R5

  AST_ATOMIC_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2) && $rose(sram_we) |-> (sram_wdata[0] == $past(br_atomic))); // R6

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) && !$past(trace_en) && !$past(trace_en, 2) |-> !sram_we); // R8

  AST_PTR_ON_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2) && !$stable(ptr) && !$past(reg_we) |-> $past(pkt_done)); // R3

  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2) && dbg_req && !(reg_we && reg_sel == 2'd1) |=> dbg_req); // R11
endmodule

bind trace_buffer trc_chk #(.PW(PW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .trace_en   (trace_en),
  .pkt_done   (pkt_done),
  .ptr        (ptr),
  .reg_we     (reg_we),
  .reg_sel    (reg_sel),
  .br_atomic  (br_atomic),
  .sram_we    (sram_we),
  .sram_addr  (sram_addr),
  .sram_wdata (sram_wdata),
  .dbg_req    (dbg_req)
);

// File: tb/test_trace_buffer.sv
`timescale 1ns/1ps
module test_trace_buffer;
  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        br_valid;
  logic [31:1] br_src;
  logic [31:1] br_dst;
  logic        br_atomic;
  logic        ext_start;
  logic        ext_stop;
  logic        sram_we;
  logic [31:0] sram_addr;
  logic [31:0] sram_wdata;
  logic        dbg_req;

  int n_chk  = 0;
  int n_fail = 0;

  trace_buffer #(.PTR_MSB(9)) i_trace_buffer (
    .clk (clk), .rst_n (rst_n),
    .reg_we (reg_we), .reg_sel (reg_sel), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
    .br_valid (br_valid), .br_src (br_src), .br_dst (br_dst), .br_atomic (br_atomic),
    .ext_start (ext_start), .ext_stop (ext_stop),
    .sram_we (sram_we), .sram_addr (sram_addr), .sram_wdata (sram_wdata), .dbg_req (dbg_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, input logic [31:0] exp, input string tag);
    reg_sel = s;
    #1;
    chk(reg_rdata, exp, tag);
  endtask

  // one record; checks both words, returns in the cycle after the record
  task automatic send_br(input logic [31:0] src, input logic [31:0] dst, input logic at,
                         input logic exp_s, input logic [31:0] exp_addr, input string tag);
    @(negedge clk);
    br_valid = 1'b1; br_src = src[31:1]; br_dst = dst[31:1]; br_atomic = at;
    @(negedge clk);
    br_valid = 1'b0;
    chk({31'd0, sram_we}, 32'd1, {tag, " R5 we0"});
    chk(sram_addr, exp_addr, {tag, " R5 addr0"});
    chk(sram_wdata, {src[31:1], at}, {tag, " R6 word0"});
    @(negedge clk);
    chk({31'd0, sram_we}, 32'd1, {tag, " R5 we1"});
    chk(sram_addr, exp_addr + 32'd4, {tag, " R5 addr1"});
    chk(sram_wdata, {dst[31:1], exp_s}, {tag, " R7 word1"});
    @(negedge clk);
  endtask

  task automatic t_reset;
    rd(2'd1, 32'h0000_0080, "R1 ctrl");
    rd(2'd0, 32'h0, "R1 pos");
    rd(2'd2, 32'h0, "R1 flow");
    rd(2'd3, 32'h0, "R1 base");
    chk({31'd0, sram_we}, 32'd0, "R1 sram_we");
    chk({31'd0, dbg_req}, 32'd0, "R1 dbg_req");
  endtask

  task automatic t_basic;
    wr(2'd3, 32'h0000_1000);
    wr(2'd1, 32'h8000_01E7);
    rd(2'd1, 32'h8000_01E7, "R2 ctrl fields");
    wr(2'd1, 32'h8000_0087);
    rd(2'd1, 32'h8000_0087, "R2 ctrl rewrite");
    send_br(32'h0000_0100, 32'h0000_0200, 1'b1, 1'b1, 32'h0000_1000, "basic1");
    rd(2'd0, 32'h0000_0008, "R3 pos after one");
    send_br(32'h0000_0303, 32'h0000_0405, 1'b0, 1'b0, 32'h0000_1008, "basic2");
    rd(2'd0, 32'h0000_0010, "R3 pos after two");
  endtask

  task automatic t_busy_ignore;
    @(negedge clk);
    br_valid = 1'b1; br_src = 31'h0000_0500 >> 1; br_dst = 31'h0000_0600 >> 1; br_atomic = 1'b0;
    @(negedge clk);
    br_src = 31'h0000_0900 >> 1; br_dst = 31'h0000_0A00 >> 1; br_atomic = 1'b1;
    chk(sram_wdata, 32'h0000_0500, "R8 busy word0");
    @(negedge clk);
    br_valid = 1'b0;
    chk(sram_wdata, 32'h0000_0600, "R8 busy word1 kept");
    @(negedge clk);
    chk({31'd0, sram_we}, 32'd0, "R8 second branch dropped");
    rd(2'd0, 32'h0000_0018, "R8 pos one record");
  endtask

  task automatic t_off_ignore;
    wr(2'd1, 32'h0000_0087);
    @(negedge clk);
    br_valid = 1'b1;
    @(negedge clk);
    br_valid = 1'b0;
    chk({31'd0, sram_we}, 32'd0, "R8 disabled no write");
    @(negedge clk);
    chk({31'd0, sram_we}, 32'd0, "R8 disabled no write2");
    rd(2'd0, 32'h0000_0018, "R8 disabled pos");
  endtask

  task automatic t_window;
    wr(2'd1, 32'h0000_0080);
    wr(2'd0, 32'h0000_0048);
    wr(2'd1, 32'h8000_0080);
    send_br(32'h0000_1110, 32'h0000_2220, 1'b0, 1'b1, 32'h0000_1048, "win1");
    rd(2'd0, 32'h0000_0044, "R4 wrap to 8 and flag");
    send_br(32'h0000_1112, 32'h0000_2222, 1'b0, 1'b0, 32'h0000_1040, "win2");
    rd(2'd0, 32'h0000_004C, "R4 sticky flag");
    wr(2'd0, 32'h0000_0018);
    rd(2'd0, 32'h0000_0018, "R4 flag cleared by write");
    wr(2'd1, 32'h8000_0081);
    send_br(32'h0000_1114, 32'h0000_2224, 1'b1, 1'b0, 32'h0000_1018, "win3");
    rd(2'd0, 32'h0000_0004, "R4 four-record window wrap");
  endtask

  task automatic t_watermark;
    wr(2'd1, 32'h0000_0087);
    wr(2'd0, 32'h0000_0000);
    wr(2'd2, 32'h0000_0011);
    rd(2'd2, 32'h0000_0011, "R10 flow readback");
    wr(2'd1, 32'h8000_0087);
    send_br(32'h0000_3000, 32'h0000_4000, 1'b0, 1'b1, 32'h0000_1000, "wm1");
    rd(2'd1, 32'h8000_0087, "R10 still on");
    send_br(32'h0000_3002, 32'h0000_4002, 1'b0, 1'b0, 32'h0000_1008, "wm2");
    rd(2'd1, 32'h0000_0087, "R10 auto-stop");
    @(negedge clk);
    br_valid = 1'b1;
    @(negedge clk);
    br_valid = 1'b0;
    chk({31'd0, sram_we}, 32'd0, "R10 stopped no write");
    rd(2'd0, 32'h0000_0010, "R10 pos held");
    wr(2'd2, 32'h0000_001A);
    wr(2'd1, 32'h8000_0087);
    chk({31'd0, dbg_req}, 32'd0, "R11 no req before");
    send_br(32'h0000_5000, 32'h0000_6000, 1'b1, 1'b1, 32'h0000_1010, "wm3");
    chk({31'd0, dbg_req}, 32'd1, "R11 req raised");
    rd(2'd1, 32'h8000_0287, "R11 halt bit");
    repeat (3) @(negedge clk);
    chk({31'd0, dbg_req}, 32'd1, "R11 req held");
    wr(2'd1, 32'h8000_0087);
    chk({31'd0, dbg_req}, 32'd0, "R11 req cleared");
  endtask

  task automatic pulse(input logic st, input logic sp);
    @(negedge clk);
    ext_start = st; ext_stop = sp;
    @(negedge clk);
    ext_start = 1'b0; ext_stop = 1'b0;
  endtask

  task automatic t_ext;
    wr(2'd2, 32'h0000_0000);
    wr(2'd1, 32'h0000_0087);
    pulse(1'b1, 1'b0);
    rd(2'd1, 32'h0000_0087, "R9 start not permitted");
    wr(2'd1, 32'h0000_00A7);
    pulse(1'b1, 1'b0);
    rd(2'd1, 32'h8000_00A7, "R9 start permitted");
    pulse(1'b0, 1'b1);
    rd(2'd1, 32'h8000_00A7, "R9 stop not permitted");
    wr(2'd1, 32'h8000_00E7);
    pulse(1'b0, 1'b1);
    rd(2'd1, 32'h0000_00E7, "R9 stop permitted");
    pulse(1'b1, 1'b1);
    rd(2'd1, 32'h0000_00E7, "R9 stop wins");
    pulse(1'b1, 1'b0);
    rd(2'd1, 32'h8000_00E7, "R9 restart");
    send_br(32'h0000_7000, 32'h0000_8000, 1'b0, 1'b1, 32'h0000_1018, "R7 restart start flag");
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = 2'd0; reg_wdata = '0;
    br_valid = 1'b0; br_src = '0; br_dst = '0; br_atomic = 1'b0;
    ext_start = 1'b0; ext_stop = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_basic;
    t_busy_ignore;
    t_off_ignore;
    t_window;
    t_watermark;
    t_ext;
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule